// File: doc/BRIEF.md
# Configurable Window Processing Cell

This block is a single cell of a two-dimensional systolic array that evaluates window operators over an image. On every clock it takes an unsigned image pixel and an unsigned mask coefficient and applies one of four scalar operations to them. It folds the scalar result into a signed local accumulator under one of four reductions, and it hands the coefficient on to its right-hand neighbour one cycle later. A 4-bit control word, sampled every cycle, chooses the scalar operation and the reduction. That lets one cell serve convolution (multiply and sum), grey-level morphology (add or subtract with maximum or minimum) and block matching (absolute difference and sum).

A clear input starts a new window. On a cleared cycle the accumulator takes the fresh scalar result and drops its old contents. The partial result leaves the cell registered, one cycle after its inputs. The accumulator width is derived from the pixel width, the coefficient width and the number of taps in a window. With the defaults (8-bit data, 7x7 window) it is 23 bits, two's complement. A full window of the largest products therefore fits with room for a sign.

Top module: `win_pe`

## Requirements
- R1: While rst_n is low, acc_o and coef_o read 0 after each clock edge.
- R2: coef_o equals the coef_i value sampled at the previous clock edge, whatever the control word or clear.
- R3: With ctrl_i[1:0] = 00 the scalar result is the unsigned product pix_i * coef_i.
- R4: With ctrl_i[1:0] = 01 the scalar result is the unsigned sum pix_i + coef_i.
- R5: With ctrl_i[1:0] = 10 the scalar result is pix_i - coef_i, sign-extended, so it is negative when coef_i > pix_i.
- R6: With ctrl_i[1:0] = 11 the scalar result is |pix_i - coef_i|, never negative.
- R7: When clear_i is high, acc_o after the edge equals the scalar result, for every reduction code.
- R8: With clear_i low and ctrl_i[3:2] = 00, acc_o after the edge is the old acc_o plus the scalar result, signed.
- R9: With clear_i low and ctrl_i[3:2] = 01, acc_o after the edge is the signed maximum of the old acc_o and the scalar result.
- R10: With clear_i low and ctrl_i[3:2] = 10, acc_o after the edge is the signed minimum of the old acc_o and the scalar result.
- R11: With ctrl_i[3:2] = 11, acc_o after the edge is the scalar result and the old value is discarded.
- R12: A cleared start followed by 48 accumulate steps of 255 * 255 gives 3186225 with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_i | input | PIX_W (8) | Unsigned image pixel |
| coef_i | input | COEF_W (8) | Unsigned mask coefficient |
| ctrl_i | input | 4 | [1:0] scalar op, [3:2] reduction |
| clear_i | input | 1 | Start a new window: load the scalar result |
| acc_o | output | ACC_W (23) | Signed partial result (accumulator) |
| coef_o | output | COEF_W (8) | Coefficient delayed one cycle, to the neighbour |

## Verification
The hardest situation to reach is the signed behaviour of the reductions once the accumulator has gone negative. A subtract step with a coefficient larger than the pixel drives it below zero. Maximum and minimum steps then follow, so that the unsigned and signed orderings of the two operands disagree. The stimulus builds that state on purpose. It then mixes clear pulses into maximum and minimum runs, which shows that clear overrides the reduction. A 49-step run of the largest products probes the top bit of the accumulator.

// File: rtl/win_pe_pkg.sv
package win_pe_pkg;

  // scalar operation, control word bits [1:0]
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_ABSD = 2'b11
  } scal_op_e;

  // reduction, control word bits [3:2]
  typedef enum logic [1:0] {
    RD_SUM  = 2'b00,
    RD_MAX  = 2'b01,
    RD_MIN  = 2'b10,
    RD_PASS = 2'b11
  } red_op_e;

  typedef struct packed {
    red_op_e  red;
    scal_op_e op;
  } ctrl_word_t;

  // one-hot merge selection after decode
  typedef struct packed {
    logic take_new;
    logic sum;
    logic max;
    logic min;
  } merge_sel_t;

endpackage

// File: rtl/win_pe_ctrl.sv
module win_pe_ctrl
  import win_pe_pkg::*;
(
  input  logic [3:0] ctrl_i,
  input  logic       clear_i,
  output scal_op_e   op_o,
  output merge_sel_t sel_o
);

  ctrl_word_t cw;

  always_comb begin
    cw    = ctrl_word_t'(ctrl_i);
    op_o  = cw.op;
    sel_o = '0;
    if (clear_i || cw.red == RD_PASS) begin
      sel_o.take_new = 1'b1;
    end else begin
      unique case (cw.red)
        RD_SUM:  sel_o.sum = 1'b1;
        RD_MAX:  sel_o.max = 1'b1;
        RD_MIN:  sel_o.min = 1'b1;
        default: sel_o.take_new = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/win_pe_alu.sv
module win_pe_alu
  import win_pe_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int RES_W  = 23
) (
  input  logic [PIX_W-1:0]        pix_i,
  input  logic [COEF_W-1:0]       coef_i,
  input  scal_op_e                op_i,
  output logic signed [RES_W-1:0] res_o,
  output logic                    diff_neg_o
);

  localparam int WIDE_IN = (PIX_W > COEF_W) ? PIX_W : COEF_W;
  localparam logic signed [RES_W-1:0] ABS_MAX = RES_W'((1 << WIDE_IN) - 1);

  function automatic logic signed [RES_W-1:0] f_zext_p(input logic [PIX_W-1:0] v);
    return signed'(RES_W'(v));
  endfunction

  function automatic logic signed [RES_W-1:0] f_zext_c(input logic [COEF_W-1:0] v);
    return signed'(RES_W'(v));
  endfunction

  function automatic logic signed [RES_W-1:0] f_abs(input logic signed [RES_W-1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  logic signed [RES_W-1:0] px, cx, diff;

  always_comb begin
    px         = f_zext_p(pix_i);
    cx         = f_zext_c(coef_i);
    diff       = px - cx;
    diff_neg_o = diff[RES_W-1];
    unique case (op_i)
      OP_MUL:  res_o = px * cx;
      OP_ADD:  res_o = px + cx;
      OP_SUB:  res_o = diff;
      OP_ABSD: res_o = f_abs(diff);
      default: res_o = '0;
    endcase
  end

  // R3: products of unsigned operands are never negative
  always_comb begin
    if (op_i == OP_MUL) p_mul_nonneg_r3: assert (res_o >= 0);
  end

  // R6: absolute difference stays in [0, max input]
  always_comb begin
    if (op_i == OP_ABSD) p_absd_range_r6: assert (res_o >= 0 && res_o <= ABS_MAX);
  end

  // R5: subtract sign agrees with the input ordering
  always_comb begin
    if (op_i == OP_SUB) p_sub_sign_r5: assert ((res_o < 0) == (f_zext_c(coef_i) > f_zext_p(pix_i)));
  end

endmodule

// File: rtl/win_pe_acc.sv
module win_pe_acc
  import win_pe_pkg::*;
#(
  parameter int RES_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [RES_W-1:0] res_i,
  input  merge_sel_t              sel_i,
  output logic signed [RES_W-1:0] acc_o
);

  function automatic logic signed [RES_W-1:0] f_merge(
    input merge_sel_t              s,
    input logic signed [RES_W-1:0] old_v,
    input logic signed [RES_W-1:0] new_v
  );
    if (s.take_new)  return new_v;
    else if (s.sum)  return old_v + new_v;
    else if (s.max)  return (new_v > old_v) ? new_v : old_v;
    else if (s.min)  return (new_v < old_v) ? new_v : old_v;
    else             return old_v;
  endfunction

  logic signed [RES_W-1:0] acc_q, acc_d;

  assign acc_d = f_merge(sel_i, acc_q, res_i);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R7 / R11: load of the fresh scalar result
  p_load_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.take_new |=> acc_q == $past(res_i));

  // R8: difference between successive values is the scalar result
  p_sum_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.sum |=> (acc_q - $past(acc_q)) == $past(res_i));

  // R9: maximum never falls and is one of the two operands
  p_max_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.max |=> acc_q >= $past(acc_q) && acc_q >= $past(res_i) &&
                  (acc_q == $past(acc_q) || acc_q == $past(res_i)));

  // R10: minimum never rises and is one of the two operands
  p_min_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.min |=> acc_q <= $past(acc_q) && acc_q <= $past(res_i) &&
                  (acc_q == $past(acc_q) || acc_q == $past(res_i)));

endmodule

// File: rtl/win_pe_coef_dly.sv
module win_pe_coef_dly #(
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef_i,
  output logic [COEF_W-1:0] coef_o
);

  logic [COEF_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= coef_i;
  end

  assign coef_o = hold_q;

  // R2: one-cycle forwarding to the neighbour
  p_coef_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> coef_o == $past(coef_i));

endmodule

// File: rtl/win_pe.sv
module win_pe
  import win_pe_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int WIN    = 7,
  localparam int TAPS  = WIN * WIN,
  localparam int ACC_W = PIX_W + COEF_W + $clog2(TAPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [3:0]        ctrl_i,
  input  logic              clear_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [COEF_W-1:0] coef_o
);

  scal_op_e                op;
  merge_sel_t              sel;
  logic signed [ACC_W-1:0] scal_res;
  logic signed [ACC_W-1:0] acc_val;
  logic                    diff_neg;

  win_pe_ctrl u_ctrl (
    .ctrl_i  (ctrl_i),
    .clear_i (clear_i),
    .op_o    (op),
    .sel_o   (sel)
  );

  win_pe_alu #(.PIX_W(PIX_W), .COEF_W(COEF_W), .RES_W(ACC_W)) u_alu (
    .pix_i      (pix_i),
    .coef_i     (coef_i),
    .op_i       (op),
    .res_o      (scal_res),
    .diff_neg_o (diff_neg)
  );

  win_pe_acc #(.RES_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .res_i (scal_res),
    .sel_i (sel),
    .acc_o (acc_val)
  );

  win_pe_coef_dly #(.COEF_W(COEF_W)) u_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .coef_i (coef_i),
    .coef_o (coef_o)
  );

  assign acc_o = acc_val;

  // R1: reset clears both registered outputs
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (acc_o == '0 && coef_o == '0));

  // R7: clear wins over every reduction code
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> sel.take_new && !sel.sum && !sel.max && !sel.min);

  // R5: a negative difference only with a larger coefficient
  p_diff_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    diff_neg |-> coef_i > COEF_W'(pix_i));

endmodule

// File: tb/test_win_pe.sv
module test_win_pe;

  localparam int ACC_W = 23;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       pix = '0;
  logic [7:0]       coef = '0;
  logic [3:0]       ctrl = '0;
  logic             clear = 1'b0;
  logic [ACC_W-1:0] acc_o;
  logic [7:0]       coef_o;

  int total = 0;
  int bad   = 0;
  int model = 0;
  int last_w = 0;

  always #5 clk = ~clk;

  win_pe i_win_pe (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_i   (pix),
    .coef_i  (coef),
    .ctrl_i  (ctrl),
    .clear_i (clear),
    .acc_o   (acc_o),
    .coef_o  (coef_o)
  );

  // reference scalar: op 0 mul, 1 add, 2 sub, 3 absdiff
  function automatic int scal_ref(input int p, input int w, input int op);
    case (op)
      0: return p * w;
      1: return p + w;
      2: return p - w;
      default: return (p > w) ? p - w : w - p;
    endcase
  endfunction

  function automatic int acc_now();
    return int'($signed(acc_o));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; model follows the requirements
  task automatic step(input int p, input int w, input int op, input int red, input bit clr);
    int s;
    @(negedge clk);
    pix = p[7:0]; coef = w[7:0]; ctrl = {red[1:0], op[1:0]}; clear = clr;
    s = scal_ref(p, w, op);
    if (clr || red == 3) model = s;
    else if (red == 0) model = model + s;
    else if (red == 1) model = (s > model) ? s : model;
    else model = (s < model) ? s : model;
    last_w = w;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pix = 8'd77; coef = 8'd99; ctrl = 4'b0000; clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 acc in reset", acc_now(), 0);
    check("R1 coef in reset", int'(coef_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model = 0;
  endtask

  task automatic t_coef;
    step(1, 17, 0, 0, 1'b1);
    check("R2 coef fwd", int'(coef_o), 17);
    step(2, 250, 2, 1, 1'b0);
    check("R2 coef fwd", int'(coef_o), 250);
    step(3, 0, 3, 3, 1'b1);
    check("R2 coef fwd", int'(coef_o), 0);
  endtask

  task automatic t_ops;
    step(12, 11, 0, 3, 1'b0);  check("R3 mul", acc_now(), 132);
    step(255, 255, 0, 0, 1'b1); check("R3 mul max", acc_now(), 65025);
    step(200, 100, 1, 3, 1'b0); check("R4 add", acc_now(), 300);
    step(255, 255, 1, 2, 1'b1); check("R4 add max", acc_now(), 510);
    step(90, 30, 2, 3, 1'b0);  check("R5 sub pos", acc_now(), 60);
    step(3, 200, 2, 3, 1'b0);  check("R5 sub neg", acc_now(), -197);
    step(10, 60, 3, 3, 1'b0);  check("R6 absdiff w>p", acc_now(), 50);
    step(250, 5, 3, 3, 1'b0);  check("R6 absdiff p>w", acc_now(), 245);
  endtask

  task automatic t_reduce;
    // R8: accumulate, going negative
    step(10, 4, 0, 0, 1'b1);   check("R8 start", acc_now(), model);
    step(0, 100, 2, 0, 1'b0);  check("R8 sum neg", acc_now(), -60);
    step(7, 7, 1, 0, 1'b0);    check("R8 sum", acc_now(), model);
    // R9: max with negative accumulator
    step(1, 120, 2, 3, 1'b0);  check("R11 pass", acc_now(), -119);
    step(0, 50, 2, 1, 1'b0);   check("R9 max keeps larger neg", acc_now(), -50);
    step(0, 90, 2, 1, 1'b0);   check("R9 max ignores smaller", acc_now(), -50);
    step(2, 3, 0, 1, 1'b0);    check("R9 max to pos", acc_now(), 6);
    // R10: min
    step(9, 9, 0, 2, 1'b0);    check("R10 min keeps", acc_now(), 6);
    step(4, 200, 2, 2, 1'b0);  check("R10 min neg", acc_now(), -196);
    step(0, 1, 2, 2, 1'b0);    check("R10 min ignores larger", acc_now(), -196);
    // R7: clear over max and min
    step(5, 5, 0, 1, 1'b1);    check("R7 clear over max", acc_now(), 25);
    step(100, 1, 2, 2, 1'b1);  check("R7 clear over min", acc_now(), 99);
    step(1, 1, 1, 0, 1'b1);    check("R7 clear over sum", acc_now(), 2);
    // R11: pass over a large value
    step(200, 200, 0, 3, 1'b0); check("R11 pass", acc_now(), 40000);
    step(1, 2, 2, 3, 1'b0);     check("R11 pass neg", acc_now(), -1);
  endtask

  task automatic t_window;
    step(255, 255, 0, 0, 1'b1);
    for (int k = 1; k < 49; k++) step(255, 255, 0, 0, 1'b0);
    check("R12 full window", acc_now(), 3186225);
    check("R12 sign bit", int'(acc_o[ACC_W-1]), 0);
    check("R2 coef after window", int'(coef_o), last_w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_coef();
    t_ops();
    t_reduce();
    t_window();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule